// File: doc/BRIEF.md
# Three-Level Page Table Walker

The walker resolves a translation after a lookup miss by reading page table entries from memory, one level at a time. It handles a three-level table with 4 KiB pages and 8-byte entries. A miss hands it the virtual page number, the address space identifier and a flag that marks an instruction fetch. The walker then reads one entry per level over a memory port with request, grant and read-valid signals. It checks each returned entry against the access being made.

Each walk ends in one of three ways. A usable leaf produces a one-cycle TLB update pulse that carries the entry and a flag for its superpage size. A malformed entry or a permission violation produces a one-cycle page-fault pulse. A read refused by physical memory protection produces a one-cycle access-fault pulse. A flush strobe abandons the walk. A flush never leaves the memory port with a grant or a read response still owed.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous reset the walker is idle, with no memory request and no update, page-fault or access-fault pulse.
- R2: A lookup request in the idle state starts a walk. The first read address is the root PPN shifted left by 12, plus the top 9-bit VPN field shifted left by 3.
- R3: While the request is high and no grant has come, the request stays high and the address stays unchanged.
- R4: An entry with V=1 (bit 0) and R=0, X=0 (bits 1 and 3) points to the next level. The next read address is the entry's PPN (bits 53:10) shifted left by 12, plus the next VPN field shifted left by 3.
- R5: An entry with V=0, or with W=1 (bit 2) and R=0, ends the walk with a one-cycle page-fault pulse and no update.
- R6: A leaf is an entry with R or X set. An instruction walk needs X. A data walk needs R, or X with the MXR input high. A store, whose flag is sampled with the lookup, also needs W and D (bit 7). A leaf that fails these checks gives a page fault.
- R7: A leaf at the top level needs PPN bits 17:0 to be zero. A leaf at the middle level needs PPN bits 8:0 to be zero. Otherwise the walk gives a page fault.
- R8: A pointer entry read at the last level gives a page fault.
- R9: A good leaf gives a one-cycle update pulse. The pulse carries the VPN, the ASID and the raw entry. The is-page flags are: bit 0 set for a top-level leaf, bit 1 set for a middle-level leaf, both clear for a last-level leaf.
- R10: If the protection-allow input is low while a read response arrives, the walk ends with a one-cycle access-fault pulse and no update. This applies even when the entry itself would fault.
- R11: A flush with a grant still due keeps the request up until the grant arrives. A flush with a response still due waits for that response. A flush never produces an update or a fault for the abandoned walk.
- R12: After an update the next lookup is accepted two cycles later. After a fault it is accepted three cycles later. Lookups that arrive earlier, or while a walk or drain is under way, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Abandon the current walk |
| lookup_req_i | input | 1 | Lookup miss, start a walk |
| lookup_vpn_i | input | 27 | Virtual page number to translate |
| lookup_asid_i | input | 16 | Address space identifier of the lookup |
| lookup_instr_i | input | 1 | Walk is for an instruction fetch |
| is_store_i | input | 1 | Walk is for a store (sampled with the lookup) |
| mxr_i | input | 1 | Execute-only pages may be read |
| root_ppn_i | input | 44 | PPN of the top-level table |
| pmp_allow_i | input | 1 | Protection allows the current entry read |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 56 | Entry read address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry read data |
| upd_valid_o | output | 1 | TLB update pulse |
| upd_vpn_o | output | 27 | VPN of the update |
| upd_asid_o | output | 16 | ASID of the update |
| upd_pte_o | output | 64 | Leaf entry of the update |
| upd_is_page_o | output | 2 | Superpage flags per upper level |
| page_fault_o | output | 1 | Page-fault pulse |
| access_fault_o | output | 1 | Access-fault pulse |

## Verification
The assertions check the following on every cycle:
- a request waiting for a grant stays up with a stable address;
- the three outcome pulses never overlap, and each lasts exactly one cycle;
- no new request follows an outcome;
- a flush seen while not requesting is followed by no request and no update.

Some behaviour can only be shown by the bench's scenarios: the read addresses at each level, the way each permission combination is classified, superpage alignment, the priority of a protection refusal, and the timing of a drain after a flush. The bench sweeps every V/R/W/X/D combination at the last level for fetch, load and store with both MXR values. It compares each result against an arithmetic model.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GRANT,
    ST_PTE_LOOKUP,
    ST_PROP_PF,
    ST_PROP_AF,
    ST_WAIT_RVALID,
    ST_LATENCY
  } walk_state_e;

  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_D = 7;
  localparam int PTE_PPN_LSB = 10;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W    = 44,
  parameter int VPN_BITS = 9,
  parameter int PAGE_LOG = 12,
  parameter int PTE_LOG  = 3,
  localparam int PA_W    = PPN_W + PAGE_LOG
) (
  input  logic [PPN_W-1:0]    base_ppn_i,
  input  logic [VPN_BITS-1:0] vpn_i,
  output logic [PA_W-1:0]     addr_o
);
  always_comb begin
    addr_o = {base_ppn_i, {PAGE_LOG{1'b0}}}
           + PA_W'({vpn_i, {PTE_LOG{1'b0}}});
  end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int LEVELS   = 3,
  parameter int VPN_BITS = 9,
  parameter int PPN_W    = 44,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int NLV     = 1 << LVL_W
) (
  input  logic             v_i,
  input  logic             r_i,
  input  logic             w_i,
  input  logic             x_i,
  input  logic             d_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             is_instr_i,
  input  logic             is_store_i,
  input  logic             mxr_i,
  output logic             leaf_ok_o,
  output logic             descend_o,
  output logic             fault_o
);
  logic [NLV-1:0] mis_vec;

  for (genvar l = 0; l < NLV; l++) begin : g_mis
    if (l < LEVELS - 1) begin : g_super
      assign mis_vec[l] = |ppn_i[(LEVELS-1-l)*VPN_BITS-1:0];
    end else begin : g_base
      assign mis_vec[l] = 1'b0;
    end
  end

  logic bad_enc, is_leaf, perm_ok, last_lvl, misaligned;

  always_comb begin
    bad_enc    = !v_i || (w_i && !r_i);
    is_leaf    = r_i || x_i;
    last_lvl   = (level_i == LVL_W'(LEVELS - 1));
    misaligned = mis_vec[level_i];
    if (is_instr_i) begin
      perm_ok = x_i;
    end else begin
      perm_ok = (r_i || (x_i && mxr_i)) && (!is_store_i || (w_i && d_i));
    end
    leaf_ok_o = !bad_enc && is_leaf && perm_ok && !misaligned;
    descend_o = !bad_enc && !is_leaf && !last_lvl;
    fault_o   = !leaf_ok_o && !descend_o;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS   = 3,
  parameter int VPN_BITS = 9,
  parameter int PAGE_LOG = 12,
  parameter int PPN_W    = 44,
  parameter int ASID_W   = 16,
  parameter int PTE_BITS = 64,
  localparam int VPN_W   = LEVELS * VPN_BITS,
  localparam int PA_W    = PPN_W + PAGE_LOG,
  localparam int PTE_LOG = $clog2(PTE_BITS / 8),
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int NLV     = 1 << LVL_W,
  localparam int PG_W    = (LEVELS > 1) ? LEVELS - 1 : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_i,
  input  logic                lookup_req_i,
  input  logic [VPN_W-1:0]    lookup_vpn_i,
  input  logic [ASID_W-1:0]   lookup_asid_i,
  input  logic                lookup_instr_i,
  input  logic                is_store_i,
  input  logic                mxr_i,
  input  logic [PPN_W-1:0]    root_ppn_i,
  input  logic                pmp_allow_i,
  output logic                mem_req_o,
  output logic [PA_W-1:0]     mem_addr_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  input  logic [PTE_BITS-1:0] mem_rdata_i,
  output logic                upd_valid_o,
  output logic [VPN_W-1:0]    upd_vpn_o,
  output logic [ASID_W-1:0]   upd_asid_o,
  output logic [PTE_BITS-1:0] upd_pte_o,
  output logic [PG_W-1:0]     upd_is_page_o,
  output logic                page_fault_o,
  output logic                access_fault_o
);
  walk_state_e         state_q, state_d;
  logic [LVL_W-1:0]    lvl_q, lvl_d, nxt_lvl;
  logic [PA_W-1:0]     ptr_q, ptr_d;
  logic [VPN_W-1:0]    vpn_q;
  logic [ASID_W-1:0]   asid_q;
  logic                instr_q, store_q, kill_q, kill_d;
  logic                load_req, upd_fire;
  logic [PG_W-1:0]     pg_d;

  // VPN fields of the captured walk, top level first
  logic [VPN_BITS-1:0] vpn_fld [NLV];
  for (genvar l = 0; l < NLV; l++) begin : g_fld
    if (l < LEVELS) begin : g_real
      assign vpn_fld[l] = vpn_q[VPN_BITS*(LEVELS-1-l) +: VPN_BITS];
    end else begin : g_pad
      assign vpn_fld[l] = '0;
    end
  end

  for (genvar l = 0; l < PG_W; l++) begin : g_pg
    assign pg_d[l] = (LEVELS > 1) && (lvl_q == LVL_W'(l));
  end

  assign nxt_lvl = lvl_q + 1'b1;

  logic [PA_W-1:0] root_addr, next_addr;

  ptw_addr_gen #(.PPN_W(PPN_W), .VPN_BITS(VPN_BITS), .PAGE_LOG(PAGE_LOG),
                 .PTE_LOG(PTE_LOG)) u_root_addr (
    .base_ppn_i (root_ppn_i),
    .vpn_i      (lookup_vpn_i[VPN_W-1 -: VPN_BITS]),
    .addr_o     (root_addr)
  );

  ptw_addr_gen #(.PPN_W(PPN_W), .VPN_BITS(VPN_BITS), .PAGE_LOG(PAGE_LOG),
                 .PTE_LOG(PTE_LOG)) u_next_addr (
    .base_ppn_i (mem_rdata_i[PTE_PPN_LSB +: PPN_W]),
    .vpn_i      (vpn_fld[nxt_lvl]),
    .addr_o     (next_addr)
  );

  logic leaf_ok, descend, pte_fault;

  ptw_pte_check #(.LEVELS(LEVELS), .VPN_BITS(VPN_BITS), .PPN_W(PPN_W)) u_check (
    .v_i        (mem_rdata_i[PTE_V]),
    .r_i        (mem_rdata_i[PTE_R]),
    .w_i        (mem_rdata_i[PTE_W]),
    .x_i        (mem_rdata_i[PTE_X]),
    .d_i        (mem_rdata_i[PTE_D]),
    .ppn_i      (mem_rdata_i[PTE_PPN_LSB +: PPN_W]),
    .level_i    (lvl_q),
    .is_instr_i (instr_q),
    .is_store_i (store_q),
    .mxr_i      (mxr_i),
    .leaf_ok_o  (leaf_ok),
    .descend_o  (descend),
    .fault_o    (pte_fault)
  );

  always_comb begin
    state_d  = state_q;
    lvl_d    = lvl_q;
    ptr_d    = ptr_q;
    load_req = 1'b0;
    upd_fire = 1'b0;
    unique case (state_q)
      ST_IDLE: if (lookup_req_i) begin
        state_d  = ST_WAIT_GRANT;
        lvl_d    = '0;
        ptr_d    = root_addr;
        load_req = 1'b1;
      end
      ST_WAIT_GRANT: if (mem_gnt_i) begin
        state_d = kill_q ? ST_WAIT_RVALID : ST_PTE_LOOKUP;
      end
      ST_PTE_LOOKUP: if (mem_rvalid_i) begin
        if (!pmp_allow_i) begin
          state_d = ST_PROP_AF;
        end else if (pte_fault) begin
          state_d = ST_PROP_PF;
        end else if (leaf_ok) begin
          state_d  = ST_LATENCY;
          upd_fire = 1'b1;
        end else if (descend) begin
          state_d = ST_WAIT_GRANT;
          lvl_d   = nxt_lvl;
          ptr_d   = next_addr;
        end
      end
      ST_PROP_PF, ST_PROP_AF: state_d = ST_LATENCY;
      ST_WAIT_RVALID: if (mem_rvalid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (flush_i) begin
      upd_fire = 1'b0;
      load_req = 1'b0;
      unique case (state_q)
        ST_WAIT_GRANT:  state_d = mem_gnt_i ? ST_WAIT_RVALID : ST_WAIT_GRANT;
        ST_PTE_LOOKUP:  state_d = mem_rvalid_i ? ST_IDLE : ST_WAIT_RVALID;
        ST_WAIT_RVALID: state_d = mem_rvalid_i ? ST_IDLE : ST_WAIT_RVALID;
        default:        state_d = ST_IDLE;
      endcase
    end
    kill_d = (state_q == ST_WAIT_GRANT) && (state_d == ST_WAIT_GRANT)
          && (kill_q || flush_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      lvl_q         <= '0;
      ptr_q         <= '0;
      kill_q        <= 1'b0;
      vpn_q         <= '0;
      asid_q        <= '0;
      instr_q       <= 1'b0;
      store_q       <= 1'b0;
      upd_valid_o   <= 1'b0;
      upd_vpn_o     <= '0;
      upd_asid_o    <= '0;
      upd_pte_o     <= '0;
      upd_is_page_o <= '0;
    end else begin
      state_q     <= state_d;
      lvl_q       <= lvl_d;
      ptr_q       <= ptr_d;
      kill_q      <= kill_d;
      upd_valid_o <= upd_fire;
      if (load_req) begin
        vpn_q   <= lookup_vpn_i;
        asid_q  <= lookup_asid_i;
        instr_q <= lookup_instr_i;
        store_q <= is_store_i;
      end
      if (upd_fire) begin
        upd_vpn_o     <= vpn_q;
        upd_asid_o    <= asid_q;
        upd_pte_o     <= mem_rdata_i;
        upd_is_page_o <= pg_d;
      end
    end
  end

  assign mem_req_o      = (state_q == ST_WAIT_GRANT);
  assign mem_addr_o     = ptr_q;
  assign page_fault_o   = (state_q == ST_PROP_PF);
  assign access_fault_o = (state_q == ST_PROP_AF);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({upd_valid_o, page_fault_o, access_fault_o})); // R10
  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_valid_o |=> !upd_valid_o && !mem_req_o); // R9
  AST_PF_PULSE: assert property (@(posedge clk) disable iff (rst)
    page_fault_o |=> !page_fault_o && !mem_req_o); // R5
  AST_AF_PULSE: assert property (@(posedge clk) disable iff (rst)
    access_fault_o |=> !access_fault_o && !mem_req_o); // R10
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush_i && !mem_req_o |=> !mem_req_o && !upd_valid_o); // R11
  AST_OUTCOME_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (upd_valid_o || page_fault_o || access_fault_o) |-> !mem_req_o); // R12
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  localparam int VPN_W = 27;
  localparam int PA_W  = 56;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, lookup_req = 1'b0, lookup_instr = 1'b0, is_store = 1'b0, mxr_in = 1'b0;
  logic [VPN_W-1:0] lookup_vpn = '0;
  logic [15:0] lookup_asid = '0;
  logic [43:0] root_ppn = '0;
  logic pmp_ok = 1'b1, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic mem_req_o, upd_valid_o, page_fault_o, access_fault_o;
  logic [PA_W-1:0] mem_addr_o;
  logic [VPN_W-1:0] upd_vpn_o;
  logic [15:0] upd_asid_o;
  logic [63:0] upd_pte_o;
  logic [1:0] upd_is_page_o;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .flush_i(flush), .lookup_req_i(lookup_req),
    .lookup_vpn_i(lookup_vpn), .lookup_asid_i(lookup_asid),
    .lookup_instr_i(lookup_instr), .is_store_i(is_store), .mxr_i(mxr_in),
    .root_ppn_i(root_ppn), .pmp_allow_i(pmp_ok), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .upd_valid_o(upd_valid_o), .upd_vpn_o(upd_vpn_o),
    .upd_asid_o(upd_asid_o), .upd_pte_o(upd_pte_o), .upd_is_page_o(upd_is_page_o),
    .page_fault_o(page_fault_o), .access_fault_o(access_fault_o)
  );

  int checks = 0, fails = 0;
  int res, nrd;
  logic [PA_W-1:0] ra [3];
  logic [VPN_W-1:0] c_vpn;
  logic [15:0] c_asid;
  logic [63:0] c_pte;
  logic [1:0] c_pg;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b0, fl};
  endfunction

  // 0 = good leaf, 1 = page fault, 2 = go down one level
  function automatic int model(input logic [63:0] p, input int lvl, input bit instr,
                               input bit st, input bit mx);
    bit v, r, w, x, d, ok;
    logic [43:0] ppn;
    v = p[0]; r = p[1]; w = p[2]; x = p[3]; d = p[7]; ppn = p[53:10];
    if (!v || (w && !r)) return 1;
    if (!(r || x)) return (lvl == 2) ? 1 : 2;
    if (instr) ok = x;
    else ok = (r || (x && mx)) && (!st || (w && d));
    if (!ok) return 1;
    if (lvl < 2 && (ppn % (44'd1 << (9 * (2 - lvl)))) != 0) return 1;
    return 0;
  endfunction

  task automatic walk(input logic [VPN_W-1:0] vpn, input logic [15:0] asid, input bit instr,
                      input bit st, input bit mx, input logic [63:0] p0, input logic [63:0] p1,
                      input logic [63:0] p2, input int bad_pmp, input int gwait);
    logic [63:0] pv [3];
    int cyc;
    bit done;
    pv[0] = p0; pv[1] = p1; pv[2] = p2;
    lookup_vpn = vpn; lookup_asid = asid; lookup_instr = instr; is_store = st; mxr_in = mx;
    lookup_req = 1'b1;
    @(negedge clk);
    lookup_req = 1'b0;
    nrd = 0; res = -1; cyc = 0; done = 0;
    while (!done && cyc < 40) begin
      if (upd_valid_o) begin
        res = 0; done = 1;
        c_vpn = upd_vpn_o; c_asid = upd_asid_o; c_pte = upd_pte_o; c_pg = upd_is_page_o;
      end else if (page_fault_o) begin
        res = 1; done = 1;
      end else if (access_fault_o) begin
        res = 2; done = 1;
      end else if (mem_req_o && nrd < 3) begin
        ra[nrd] = mem_addr_o;
        for (int k = 0; k < gwait; k++) begin
          @(negedge clk);
          chk("R3", "request held", 64'(mem_req_o), 64'd1);
          chk("R3", "address stable", 64'(mem_addr_o), 64'(ra[nrd]));
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = pv[nrd]; pmp_ok = (nrd != bad_pmp);
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = '0; pmp_ok = 1'b1;
        nrd++;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
  endtask

  task automatic run_case(input string tag, input logic [VPN_W-1:0] vpn, input logic [15:0] asid,
                          input bit instr, input bit st, input bit mx, input logic [43:0] root,
                          input logic [63:0] p0, input logic [63:0] p1, input logic [63:0] p2,
                          input int bad_pmp, input int gwait);
    logic [63:0] pv [3];
    logic [43:0] base;
    logic [PA_W-1:0] ea;
    int exp_res, exp_n, lf, m;
    pv[0] = p0; pv[1] = p1; pv[2] = p2;
    root_ppn = root;
    walk(vpn, asid, instr, st, mx, p0, p1, p2, bad_pmp, gwait);
    base = root; exp_res = -1; exp_n = 0; lf = 0;
    for (int l = 0; l < 3 && exp_res < 0; l++) begin
      ea = {base, 12'b0} + PA_W'({vpn[9*(2-l) +: 9], 3'b0});
      exp_n = l + 1;
      if (l < nrd) chk(l == 0 ? "R2" : "R4", "entry address", 64'(ra[l]), 64'(ea));
      if (l == bad_pmp) exp_res = 2;
      else begin
        m = model(pv[l], l, instr, st, mx);
        if (m == 0) begin exp_res = 0; lf = l; end
        else if (m == 1) exp_res = 1;
        else base = pv[l][53:10];
      end
    end
    chk(tag, "outcome", 64'(res), 64'(exp_res));
    chk(tag, "entry reads", 64'(nrd), 64'(exp_n));
    if (exp_res == 0 && res == 0) begin
      chk("R9", "update vpn", 64'(c_vpn), 64'(vpn));
      chk("R9", "update asid", 64'(c_asid), 64'(asid));
      chk("R9", "update entry", c_pte, pv[lf]);
      chk("R9", "update is-page", 64'(c_pg), (lf < 2) ? 64'(1 << lf) : 64'd0);
    end
    repeat (3) @(negedge clk);
  endtask

  localparam logic [7:0] PTR = 8'h01;
  localparam logic [7:0] LEAF = 8'hCF;

  initial begin
    repeat (1000000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "req after reset", 64'(mem_req_o), 0);
    chk("R1", "outcomes after reset", 64'({upd_valid_o, page_fault_o, access_fault_o}), 0);

    // sweep of last-level permission bits, access kind and MXR
    for (int f = 0; f < 32; f++)
      for (int mode = 0; mode < 3; mode++)
        for (int mx = 0; mx < 2; mx++) begin
          int idx;
          logic [7:0] fl;
          string tg;
          idx = f * 6 + mode * 2 + mx;
          fl = {f[4], 1'b1, 2'b0, f[3], f[2], f[1], f[0]};
          if (!f[0] || (f[2] && !f[1])) tg = "R5";
          else if (!(f[1] || f[3])) tg = "R8";
          else tg = "R6";
          run_case(tg, {9'(idx * 7 + 1), 9'(idx * 13 + 5), 9'(idx * 29 + 3)}, 16'(idx * 331),
                   mode == 0, mode == 2, mx[0], 44'h1234 + 44'(idx),
                   mk(44'h5_0000 + 44'(idx), PTR), mk(44'h9_0000 + 44'(idx), PTR),
                   mk(44'hA_BCDE + 44'(idx), fl), -1, idx % 3);
        end

    // superpage leaves, aligned and misaligned
    for (int lv = 0; lv < 2; lv++)
      for (int al = 0; al < 3; al++) begin
        logic [43:0] sp;
        logic [63:0] q0, q1;
        int sh;
        sh = 9 * (2 - lv);
        sp = 44'h7 << sh;
        if (al == 1) sp = sp | 44'd1;
        if (al == 2) sp = sp | (44'd1 << (sh - 1));
        q0 = (lv == 0) ? mk(sp, LEAF) : mk(44'h33_0000, PTR);
        q1 = mk(sp, LEAF);
        run_case(al == 0 ? "R9" : "R7", {9'(lv * 40 + al), 9'd77, 9'd300},
                 16'h0A00 + 16'(al), 1'b0, 1'b1, 1'b0, 44'h2_0000 + 44'(lv),
                 q0, q1, mk(44'h1, LEAF), -1, al);
      end

    // reserved encoding at the top level
    run_case("R5", 27'h155_AAAA, 16'h11, 1'b0, 1'b0, 1'b0, 44'h42, mk(44'h9, 8'h05), 0, 0, -1, 0);

    // protection refusal at each level, including over a faulty entry
    for (int b = 0; b < 3; b++) begin
      run_case("R10", {9'(b + 3), 9'd11, 9'd500}, 16'h7000, 1'b0, 1'b0, 1'b0, 44'h77,
               b == 0 ? 64'd0 : mk(44'h8_0000, PTR), b == 1 ? 64'd0 : mk(44'hC_0000, PTR),
               mk(44'hD, LEAF), b, 1);
    end
    run_case("R10", 27'h3_0303, 16'h5, 1'b1, 1'b0, 1'b0, 44'h99,
             mk(44'h8_0000, PTR), mk(44'hC_0000, PTR), mk(44'hD, LEAF), 2, 0);

    // R11: flush while a grant is owed
    root_ppn = 44'h10;
    lookup_vpn = 27'h12345; lookup_instr = 1'b0; is_store = 1'b0; lookup_req = 1'b1;
    @(negedge clk); lookup_req = 1'b0;
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    chk("R11", "request kept after flush", 64'(mem_req_o), 1);
    repeat (2) @(negedge clk);
    chk("R11", "request still kept", 64'(mem_req_o), 1);
    mem_gnt = 1'b1; @(negedge clk); mem_gnt = 1'b0;
    chk("R11", "request dropped after grant", 64'(mem_req_o), 0);
    mem_rvalid = 1'b1; mem_rdata = mk(44'h3, LEAF); @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R11", "no outcome after drain", 64'({upd_valid_o, page_fault_o, access_fault_o}), 0);
    @(negedge clk);
    chk("R11", "idle after drain", 64'(mem_req_o), 0);
    run_case("R11", 27'h4_4444, 16'h3, 1'b0, 1'b0, 1'b0, 44'h20,
             mk(44'h8_0000, PTR), mk(44'hC_0000, PTR), mk(44'hD, LEAF), -1, 0);

    // R11: flush while a response is owed, lookup during drain ignored
    lookup_req = 1'b1; @(negedge clk); lookup_req = 1'b0;
    mem_gnt = 1'b1; @(negedge clk); mem_gnt = 0;
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    lookup_req = 1'b1; @(negedge clk); lookup_req = 1'b0;
    chk("R12", "lookup ignored while draining", 64'(mem_req_o), 0);
    mem_rvalid = 1'b1; mem_rdata = mk(44'h3, LEAF); @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R11", "drained response gives no update", 64'({upd_valid_o, page_fault_o, access_fault_o}), 0);
    @(negedge clk);
    chk("R11", "idle after response drain", 64'(mem_req_o), 0);

    // R11: flush together with the response
    lookup_req = 1'b1; @(negedge clk); lookup_req = 1'b0;
    mem_gnt = 1'b1; @(negedge clk); mem_gnt = 0;
    mem_rvalid = 1'b1; flush = 1'b1; mem_rdata = mk(44'h0, 8'h00); @(negedge clk);
    mem_rvalid = 1'b0; flush = 1'b0;
    chk("R11", "flush with response: no fault", 64'({upd_valid_o, page_fault_o, access_fault_o}), 0);
    chk("R11", "flush with response: idle", 64'(mem_req_o), 0);
    repeat (2) @(negedge clk);

    // R12: acceptance delay after an update
    root_ppn = 44'h30;
    walk(27'h1_0001, 16'h1, 1'b0, 1'b0, 1'b0, mk(44'h8_0000, PTR), mk(44'hC_0000, PTR),
         mk(44'hD, LEAF), -1, 0);
    chk("R12", "update seen", 64'(res), 0);
    lookup_req = 1'b1; @(negedge clk);
    chk("R12", "lookup during latency ignored", 64'(mem_req_o), 0);
    @(negedge clk); lookup_req = 1'b0;
    chk("R12", "lookup accepted two cycles after update", 64'(mem_req_o), 1);
    mem_gnt = 1'b1; @(negedge clk); mem_gnt = 1'b0;
    mem_rvalid = 1'b1; mem_rdata = 64'd0; @(negedge clk); mem_rvalid = 1'b0;
    chk("R5", "invalid entry faults", 64'(page_fault_o), 1);
    // R12: acceptance delay after a fault
    lookup_req = 1'b1; @(negedge clk);
    chk("R12", "lookup ignored after fault, cycle 1", 64'(mem_req_o), 0);
    chk("R5", "fault pulse one cycle", 64'(page_fault_o), 0);
    @(negedge clk);
    chk("R12", "lookup ignored after fault, cycle 2", 64'(mem_req_o), 0);
    @(negedge clk); lookup_req = 1'b0;
    chk("R12", "lookup accepted three cycles after fault", 64'(mem_req_o), 1);
    mem_gnt = 1'b1; @(negedge clk); mem_gnt = 1'b0;
    mem_rvalid = 1'b1; mem_rdata = mk(44'h3, 8'h00); @(negedge clk); mem_rvalid = 1'b0;
    repeat (6) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule